// File: doc/BRIEF.md
# Event-Triggered Cycle Countdown Clock Stopper

This block lets a debugger run a processor core for an exact number of clock cycles and then freeze it. A 48-bit count is written through a load port, which arms the block. The counter does not start on load. It waits until an event line, picked by a small trigger-select register, is seen high. Typical event lines are an interrupt request or a debug event. After that trigger the counter steps down once per core cycle. When it reaches zero, the block drops a registered clock-enable output that feeds the core clock gating, and it raises a done flag.

The stopped state lasts until the next load. A new load also cancels a run that is still counting and arms the block again. A preset of zero freezes the core as soon as the trigger is seen. The output is only an enable signal. The gating cell itself sits outside this block.

Top module: `cycle_halt_counter`

## Requirements
- R1: After synchronous reset, `core_clk_en` is 1, `done` is 0 and the trigger select is 0. Until the first load, no event input changes either output.
- R2: A cycle with `load_valid`=1 stores `load_value` (all 48 bits) as the count and arms the block. After that edge, `core_clk_en` is 1 and `done` is 0.
- R3: A cycle with `sel_write`=1 stores `sel_value` as the trigger select, and it takes effect from the next cycle. Select value i (0 ≤ i < NUM_EVT) chooses `events[i]`. A select value of NUM_EVT or above chooses no event, so the block never triggers.
- R4: While armed, event lines other than the selected one have no effect. The block stays armed and `core_clk_en` stays 1.
- R5: If the block is armed with count N > 0 and the selected event is high at an edge (the trigger edge), `core_clk_en` stays 1 for the next N-1 edges. It falls to 0 at the N-th edge after the trigger edge, and `done` rises at that same edge.
- R6: If the block is armed with count 0, `core_clk_en` falls to 0 and `done` rises at the trigger edge itself.
- R7: Once `done` is 1, it stays 1 and `core_clk_en` stays 0 until the next load. Events and select writes do not change this.
- R8: A load while counting stops the current run. The block re-arms with the new value and waits for a fresh trigger before it counts again.
- R9: If a load and the selected event arrive in the same cycle, the load wins. That event does not start counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Write `load_value` as the count and arm |
| load_value | input | CNT_W (48) | Preset count |
| sel_write | input | 1 | Write `sel_value` into the trigger-select register |
| sel_value | input | SEL_W (3) | Index of the event line that starts counting |
| events | input | NUM_EVT (6) | Candidate trigger lines, sampled at each edge |
| core_clk_en | output | 1 | Registered enable for the core clocks; 0 stops them |
| done | output | 1 | Registered completion flag |

## Verification
If the stored count is wrong, the clock-enable falls at the wrong edge. The fall comes early or late by exactly the error, so a per-edge comparison against a model reports it within one cycle of the expected stop. If the armed, running or stopped state is wrong, the outputs show it right away: a missed or false trigger, a stop that clears by itself, or a load that fails to re-arm. Each of these changes `core_clk_en` or `done` at the edge after the faulty decision. The corner cases exercised are a zero preset, an out-of-range select, a load arriving together with a trigger, and an abort of a large 48-bit count.

// File: rtl/cyc_halt_pkg.sv
package cyc_halt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HALT  = 2'd3
  } halt_state_t;
endpackage

// File: rtl/cyc_halt_trigsel.sv
module cyc_halt_trigsel #(
  parameter int NUM_EVT = 6,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_write,
  input  logic [SEL_W-1:0]   sel_value,
  input  logic [NUM_EVT-1:0] events,
  output logic               trig
);
  logic [SEL_W-1:0]   sel_q;
  logic [NUM_EVT-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst)            sel_q <= '0;
    else if (sel_write) sel_q <= sel_value;
  end

  // one comparator per event line; indices at or above NUM_EVT never match
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_hit
    assign hit[i] = events[i] && (sel_q == SEL_W'(i));
  end

  assign trig = |hit;
endmodule

// File: rtl/cyc_halt_counter.sv
module cyc_halt_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_one
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);
endmodule

// File: rtl/cyc_halt_fsm.sv
module cyc_halt_fsm
  import cyc_halt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic trig,
  input  logic cnt_zero,
  input  logic cnt_one,
  output logic dec,
  output logic clk_en,
  output logic done
);
  halt_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    dec  = 1'b0;
    if (load) begin
      st_d = ST_ARMED;
    end else begin
      unique case (st_q)
        ST_ARMED: if (trig) st_d = cnt_zero ? ST_HALT : ST_RUN;
        ST_RUN: begin
          dec = 1'b1;
          if (cnt_one) st_d = ST_HALT;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      clk_en <= 1'b1;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      clk_en <= (st_d != ST_HALT);
      done   <= (st_d == ST_HALT);
    end
  end

  // R2
  load_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (clk_en && !done && st_q == ST_ARMED));
  // R4
  armed_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ARMED && !trig && !load) |=> (st_q == ST_ARMED && clk_en));
  // R5
  last_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && cnt_one && !load) |=> (done && !clk_en));
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && !clk_en));
endmodule

// File: rtl/cycle_halt_counter.sv
module cycle_halt_counter #(
  parameter int CNT_W   = 48,
  parameter int NUM_EVT = 6,
  localparam int SEL_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_valid,
  input  logic [CNT_W-1:0]   load_value,
  input  logic               sel_write,
  input  logic [SEL_W-1:0]   sel_value,
  input  logic [NUM_EVT-1:0] events,
  output logic               core_clk_en,
  output logic               done
);
  logic trig, dec, cnt_zero, cnt_one;

  cyc_halt_trigsel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst(rst), .sel_write(sel_write), .sel_value(sel_value),
    .events(events), .trig(trig)
  );

  cyc_halt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_valid), .load_val(load_value),
    .dec(dec), .is_zero(cnt_zero), .is_one(cnt_one)
  );

  cyc_halt_fsm u_fsm (
    .clk(clk), .rst(rst), .load(load_valid), .trig(trig),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one), .dec(dec),
    .clk_en(core_clk_en), .done(done)
  );
endmodule

// File: tb/cycle_halt_counter_test.sv
module cycle_halt_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 48;
  localparam int NUM_EVT    = 6;
  localparam int SEL_W      = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               load_valid = 1'b0;
  logic [CNT_W-1:0]   load_value = '0;
  logic               sel_write = 1'b0;
  logic [SEL_W-1:0]   sel_value = '0;
  logic [NUM_EVT-1:0] events = '0;
  logic               core_clk_en, done;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  // reference model: 0 idle, 1 armed, 2 counting, 3 stopped
  int          m_st  = 0;
  longint      m_cnt = 0;
  int          m_sel = 0;

  cycle_halt_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_value(load_value),
    .sel_write(sel_write), .sel_value(sel_value), .events(events),
    .core_clk_en(core_clk_en), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit ld, input logic [CNT_W-1:0] val,
                      input bit sw, input logic [SEL_W-1:0] sv,
                      input logic [NUM_EVT-1:0] ev);
    int old_sel;
    @(negedge clk);
    rst = r; load_valid = ld; load_value = val;
    sel_write = sw; sel_value = sv; events = ev;
    @(posedge clk);
    if (r) begin
      m_st = 0; m_cnt = 0; m_sel = 0;
    end else begin
      old_sel = m_sel;
      if (sw) m_sel = int'(sv);
      if (ld) begin
        m_cnt = longint'(val); m_st = 1;
      end else if (m_st == 1) begin
        if (old_sel < NUM_EVT && ev[old_sel]) m_st = (m_cnt == 0) ? 3 : 2;
      end else if (m_st == 2) begin
        m_cnt--;
        if (m_cnt == 0) m_st = 3;
      end
    end
    #1;
    check(req, "core_clk_en", longint'(core_clk_en), (m_st != 3) ? 1 : 0);
    check(req, "done", longint'(done), (m_st == 3) ? 1 : 0);
  endtask

  task automatic idle(input int n, input logic [NUM_EVT-1:0] ev);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0, ev);
  endtask

  // edges with core_clk_en still high after the trigger edge, plus the stopping edge
  task automatic measure(input string tag, input int n_exp);
    int k = 0;
    while (core_clk_en && k < 200) begin
      step(0, 0, '0, 0, '0, '0);
      k++;
    end
    check(tag, "edges from trigger to stop", k, n_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state and events ignored before any load
    req = "R1";
    for (int i = 0; i < 3; i++) step(1, 0, '0, 0, '0, '0);
    check("R1", "reset core_clk_en", longint'(core_clk_en), 1);
    idle(5, '1);
    check("R1", "idle after events", longint'(done), 0);

    // R2 load arms, R3 select line 2, R4 other lines ignored
    req = "R3";
    step(0, 0, '0, 1, 3'd2, '0);
    req = "R2";
    step(0, 1, 48'd5, 0, '0, '0);
    check("R2", "armed core_clk_en", longint'(core_clk_en), 1);
    req = "R4";
    idle(6, 6'b111011);
    check("R4", "still running", longint'(core_clk_en), 1);
    req = "R5";
    step(0, 0, '0, 0, '0, 6'b000100);
    measure("R5", 5);
    check("R5", "done after count", longint'(done), 1);

    // R7 stop holds through events and select writes
    req = "R7";
    idle(3, '1);
    step(0, 0, '0, 1, 3'd0, '1);
    idle(3, '1);
    check("R7", "held done", longint'(done), 1);
    check("R7", "held core_clk_en", longint'(core_clk_en), 0);

    // R6 zero preset stops at the trigger edge
    req = "R6";
    step(0, 1, 48'd0, 0, '0, '0);
    step(0, 0, '0, 0, '0, 6'b000001);
    check("R6", "zero preset done", longint'(done), 1);
    check("R6", "zero preset core_clk_en", longint'(core_clk_en), 0);

    // R8 abort of a large count, re-arm, new trigger needed
    req = "R8";
    step(0, 0, '0, 1, 3'd5, '0);
    step(0, 1, 48'hFFFF_FFFF_FFFF, 0, '0, '0);
    step(0, 0, '0, 0, '0, 6'b100000);
    idle(10, '0);
    check("R8", "large count running", longint'(core_clk_en), 1);
    step(0, 1, 48'd3, 0, '0, '0);
    idle(6, '0);
    check("R8", "re-armed waits", longint'(core_clk_en), 1);
    step(0, 0, '0, 0, '0, 6'b100000);
    measure("R8", 3);

    // R9 load beats a simultaneous trigger
    req = "R9";
    step(0, 1, 48'd4, 0, '0, 6'b100000);
    idle(8, '0);
    check("R9", "trigger lost to load", longint'(core_clk_en), 1);
    step(0, 0, '0, 0, '0, 6'b100000);
    measure("R9", 4);

    // R3 out-of-range select, then switch select while armed
    req = "R3";
    step(0, 0, '0, 1, 3'd7, '0);
    step(0, 1, 48'd2, 0, '0, '0);
    idle(10, '1);
    check("R3", "out-of-range select", longint'(core_clk_en), 1);
    step(0, 0, '0, 1, 3'd1, '0);
    step(0, 0, '0, 0, '0, 6'b000010);
    measure("R3", 2);

    // R1 reset in the middle of a run
    req = "R1";
    step(0, 1, 48'd50, 0, '0, '0);
    step(0, 0, '0, 0, '0, 6'b000010);
    idle(3, '0);
    step(1, 0, '0, 0, '0, '0);
    idle(60, '1);
    check("R1", "reset aborts run", longint'(core_clk_en), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule